// File: doc/BRIEF.md
# Sensor Register Bus Slave

This block connects a light-sensing core to a two-wire serial bus (I2C) as a slave with a hardwired 7-bit address of 0x44. It samples the bus clock and data lines with the system clock, recognises START and STOP conditions, and shifts in the device-address byte, a register-select byte and data bytes. It acknowledges by pulling the data line low through an open-drain output enable, and it shifts read data out the same way. Clock stretching, general call and 10-bit addressing are not supported.

The slave holds a small register bank for the core. There is a command byte, a control byte with an interrupt flag, and upper and lower threshold bytes. Four read-only bytes show the sensor and timer counts. The two top bits of the register-select byte are commands that can only be written. Bit 7 sends a sync pulse, which ends one integration and starts the next. Bit 6 sends an interrupt-clear pulse. A write that carries only the address byte and the register-select byte, followed by STOP, is a complete transaction, so a host can issue these commands alone.

Top module: `sensor_reg_i2c`

## Requirements
- R1: The slave acknowledges only a device-address byte whose top seven bits are 7'b1000100, with bit 0 set to 1 for a read. For any other address it gives no acknowledge and ignores every byte until the next START.
- R2: A START is a fall of SDA while SCL is high. It restarts byte reception at any point, which is how a repeated START works. A STOP is a rise of SDA while SCL is high, and it returns the slave to idle. The register pointer keeps its value across both conditions.
- R3: In a write, the slave acknowledges the register-select byte and every data byte. Each data byte goes to the register that the pointer selects, and then the pointer advances by one, wrapping from 7 to 0. The pointer also advances after each byte that is read.
- R4: In a read, after a repeated START and the address with the read bit set, the slave drives the selected register MSB first. It keeps sending bytes while the master acknowledges them. It stops after the master does not acknowledge a byte.
- R5: A register-select byte with bit 7 set makes `syncPulse` high for exactly one system clock, in the same cycle that the slave starts to acknowledge that byte. This also happens when STOP follows at once.
- R6: A register-select byte with bit 6 set makes `intClrPulse` high for one system clock and clears the interrupt flag. If `intFlagSet` is high in the same cycle, setting the flag takes priority.
- R7: After reset, the registers hold command = 0x00, control = 0x00, upper threshold = 0xFF and lower threshold = 0x00. The SDA output enable is released.
- R8: In the control register, bits 7, 6 and 4 always read 0, and bits 3:0 take the value written. Bit 5 is the interrupt flag: `intFlagSet` sets it, writing 0 to it clears it, and writing 1 to it leaves it unchanged.
- R9: Addresses 4 to 7 are read-only. A write to one of them is acknowledged but changes nothing.
- R10: Only bits 2:0 of the register-select byte choose the register. Bits 5:3 are ignored.
- R11: Address 4 reads the low byte of the sensor count and address 6 reads the low byte of the timer count. Reading either low byte captures the matching high byte. Addresses 5 and 7 return that captured high byte, so later changes to the count do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| sensorData | input | 16 | Latest sensor count from the core |
| timerData | input | 16 | Timer count for the latest reading |
| intFlagSet | input | 1 | Core event that sets the interrupt flag |
| cmdReg | output | 8 | Command register (address 0) |
| ctrlReg | output | 8 | Control register (address 1) |
| thrHigh | output | 8 | Upper threshold byte (address 2) |
| thrLow | output | 8 | Lower threshold byte (address 3) |
| syncPulse | output | 1 | One-cycle integration sync command |
| intClrPulse | output | 1 | One-cycle interrupt-clear command |

## Verification
The bench sends a write to address 0x45, the neighbour of the real address. A slave that compared too few address bits would acknowledge it and corrupt the command byte. It sends transactions that carry only a command, with no data byte. A slave that raised its strobes only on a data byte would miss these, and the scoreboard then finds expected strobes that never arrived. The bench also checks that writing 1 to the interrupt flag does not set it, and that a register-select byte with bits 5:3 set still selects the correct register. It reads a high byte after the count has changed; a slave without the capture would return the new value instead of the old one. A three-byte read starting at address 6 checks that the pointer wraps from 7 to 0.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    P_IDLE, P_DEV, P_REG, P_WR, P_RD
  } busPhase_t;

  typedef struct packed {
    logic              ptrLoad;
    logic              wrByte;
    logic              rdTake;
    logic              syncCmd;
    logic              clrCmd;
    logic [BYTE_W-1:0] byteVal;
  } hostStrobe_t;
endpackage

// File: rtl/sreg_bus_ctrl.sv
module sreg_bus_ctrl
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdByte,
  output logic              sdaOe,
  output hostStrobe_t       strb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow   = sclSync[SYNC_N-1];
  assign sdaNow   = sdaSync[SYNC_N-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busPhase_t         phase;
  logic [CNT_W-1:0]  bitCnt;
  logic              ackPhase;
  logic              masterNack;
  logic [BYTE_W-1:0] shIn, shOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= P_IDLE;
      bitCnt     <= '0;
      ackPhase   <= 1'b0;
      masterNack <= 1'b0;
      shIn       <= '0;
      shOut      <= '0;
      sdaOe      <= 1'b0;
      strb       <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        phase    <= P_DEV;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (stopDet) begin
        phase    <= P_IDLE;
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (phase != P_IDLE) begin
        if (sclRise) begin
          if (!ackPhase) begin
            shIn   <= {shIn[BYTE_W-2:0], sdaNow};
            bitCnt <= bitCnt + 1'b1;
          end else if (phase == P_RD) begin
            masterNack <= sdaNow;
          end
        end else if (sclFall) begin
          if (ackPhase) begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            sdaOe    <= 1'b0;
            if (phase == P_RD) begin
              if (masterNack) begin
                phase <= P_IDLE;
              end else begin
                shOut       <= rdByte;
                sdaOe       <= ~rdByte[BYTE_W-1];
                strb.rdTake <= 1'b1;
              end
            end
          end else if (bitCnt == CNT_W'(BYTE_W)) begin
            case (phase)
              P_DEV: begin
                if (shIn[BYTE_W-1:1] == DEV_ADDR) begin
                  ackPhase   <= 1'b1;
                  sdaOe      <= 1'b1;
                  masterNack <= 1'b0;
                  phase      <= shIn[0] ? P_RD : P_REG;
                end else begin
                  phase <= P_IDLE;
                end
              end
              P_REG: begin
                ackPhase     <= 1'b1;
                sdaOe        <= 1'b1;
                strb.ptrLoad <= 1'b1;
                strb.syncCmd <= shIn[BYTE_W-1];
                strb.clrCmd  <= shIn[BYTE_W-2];
                strb.byteVal <= shIn;
                phase        <= P_WR;
              end
              P_WR: begin
                ackPhase     <= 1'b1;
                sdaOe        <= 1'b1;
                strb.wrByte  <= 1'b1;
                strb.byteVal <= shIn;
              end
              P_RD: begin
                ackPhase <= 1'b1;
                sdaOe    <= 1'b0;
              end
              default: ;
            endcase
          end else if (phase == P_RD) begin
            shOut <= {shOut[BYTE_W-2:0], 1'b0};
            sdaOe <= ~shOut[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         strb,
  input  logic [2*BYTE_W-1:0] sensorData,
  input  logic [2*BYTE_W-1:0] timerData,
  input  logic                intFlagSet,
  output logic [BYTE_W-1:0]   cmdReg,
  output logic [BYTE_W-1:0]   ctrlReg,
  output logic [BYTE_W-1:0]   thrHigh,
  output logic [BYTE_W-1:0]   thrLow,
  output logic [BYTE_W-1:0]   rdByte,
  output logic                syncPulse,
  output logic                intClrPulse
);
  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_THH  = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_THL  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_SLO  = REG_AW'(4);
  localparam logic [REG_AW-1:0] A_SHI  = REG_AW'(5);
  localparam logic [REG_AW-1:0] A_TLO  = REG_AW'(6);
  localparam logic [REG_AW-1:0] A_THI  = REG_AW'(7);
  localparam int FLAG_BIT = 5;

  logic [REG_AW-1:0] ptr;
  logic [3:0]        ctrlLow;
  logic              intFlag;
  logic [BYTE_W-1:0] snapSensor, snapTimer;
  logic              ctrlWr;

  assign ctrlWr = strb.wrByte && (ptr == A_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr        <= '0;
      cmdReg     <= '0;
      ctrlLow    <= '0;
      intFlag    <= 1'b0;
      thrHigh    <= '1;
      thrLow     <= '0;
      snapSensor <= '0;
      snapTimer  <= '0;
    end else begin
      if (strb.ptrLoad)
        ptr <= strb.byteVal[REG_AW-1:0];
      else if (strb.wrByte || strb.rdTake)
        ptr <= ptr + 1'b1;

      if (strb.wrByte) begin
        case (ptr)
          A_CMD:   cmdReg  <= strb.byteVal;
          A_CTRL:  ctrlLow <= strb.byteVal[3:0];
          A_THH:   thrHigh <= strb.byteVal;
          A_THL:   thrLow  <= strb.byteVal;
          default: ;
        endcase
      end

      if (intFlagSet)
        intFlag <= 1'b1;
      else if (strb.clrCmd || (ctrlWr && !strb.byteVal[FLAG_BIT]))
        intFlag <= 1'b0;

      if (strb.rdTake && ptr == A_SLO) snapSensor <= sensorData[2*BYTE_W-1:BYTE_W];
      if (strb.rdTake && ptr == A_TLO) snapTimer  <= timerData[2*BYTE_W-1:BYTE_W];
    end
  end

  assign ctrlReg     = {2'b00, intFlag, 1'b0, ctrlLow};
  assign syncPulse   = strb.syncCmd;
  assign intClrPulse = strb.clrCmd;

  always_comb begin
    case (ptr)
      A_CMD:   rdByte = cmdReg;
      A_CTRL:  rdByte = ctrlReg;
      A_THH:   rdByte = thrHigh;
      A_THL:   rdByte = thrLow;
      A_SLO:   rdByte = sensorData[BYTE_W-1:0];
      A_SHI:   rdByte = snapSensor;
      A_TLO:   rdByte = timerData[BYTE_W-1:0];
      A_THI:   rdByte = snapTimer;
      default: rdByte = '0;
    endcase
  end
endmodule

// File: rtl/sensor_reg_i2c.sv
module sensor_reg_i2c
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         REG_AW   = 3,
  parameter int         SYNC_N   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic [15:0] sensorData,
  input  logic [15:0] timerData,
  input  logic        intFlagSet,
  output logic [7:0]  cmdReg,
  output logic [7:0]  ctrlReg,
  output logic [7:0]  thrHigh,
  output logic [7:0]  thrLow,
  output logic        syncPulse,
  output logic        intClrPulse
);
  hostStrobe_t       strb;
  logic [BYTE_W-1:0] rdByte;

  sreg_bus_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .sdaOe(sdaOe), .strb(strb)
  );

  sreg_file #(.REG_AW(REG_AW)) u_file (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sensorData(sensorData), .timerData(timerData), .intFlagSet(intFlagSet),
    .cmdReg(cmdReg), .ctrlReg(ctrlReg), .thrHigh(thrHigh), .thrLow(thrLow),
    .rdByte(rdByte), .syncPulse(syncPulse), .intClrPulse(intClrPulse)
  );
endmodule

// File: rtl/sreg_i2c_chk.sv
module sreg_i2c_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       intFlagSet,
  input logic [7:0] ctrlReg,
  input logic       syncPulse,
  input logic       intClrPulse
);
  // R5
  sync_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse);

  // R5
  sync_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |-> sdaOe);

  // R6
  clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intClrPulse && !intFlagSet) |=> !ctrlReg[5]);

  // R6
  clr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    intClrPulse |=> !intClrPulse);

  // R8
  ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[7:6] == 2'b00) && !ctrlReg[4]);

  // R2
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind sensor_reg_i2c sreg_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .intFlagSet(intFlagSet), .ctrlReg(ctrlReg),
  .syncPulse(syncPulse), .intClrPulse(intClrPulse)
);

// File: tb/test_sensor_reg_i2c.sv
module test_sensor_reg_i2c;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h44;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  logic [15:0] sensorData = 16'h1234, timerData = 16'h5678;
  logic intFlagSet = 1'b0;
  logic [7:0] cmdReg, ctrlReg, thrHigh, thrLow;
  logic syncPulse, intClrPulse;
  wire sdaBus = mSda & ~sdaOe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] expQ[$];
  logic [7:0] wrBuf[4];
  logic [7:0] rdBuf[4];
  int ackCnt;

  always #4 clk = ~clk;

  sensor_reg_i2c i_sensor_reg_i2c (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .sensorData(sensorData), .timerData(timerData), .intFlagSet(intFlagSet),
    .cmdReg(cmdReg), .ctrlReg(ctrlReg), .thrHigh(thrHigh), .thrLow(thrLow),
    .syncPulse(syncPulse), .intClrPulse(intClrPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: strobe code {sync, clr}
  always @(negedge clk) begin
    if (rstN && (syncPulse || intClrPulse)) begin
      if (expQ.size() == 0) check("R5 R6 unexpected strobe", {syncPulse, intClrPulse}, 2'b00);
      else check("R5 R6 strobe", {syncPulse, intClrPulse}, expQ.pop_front());
    end
  end

  task automatic busStart();
    mSda = 1; tick(Q); scl = 1; tick(Q); mSda = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 0; tick(Q); scl = 1; tick(Q); mSda = 1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
    mSda = 1; tick(Q); scl = 1; tick(Q); ack = !sdaBus; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    mSda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q); b[i] = sdaBus; tick(Q); scl = 0;
    end
    mSda = nack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); mSda = 1;
  endtask

  task automatic writeTxn(input logic [6:0] dev, input logic [7:0] regByte, input int n);
    bit a;
    ackCnt = 0;
    busStart();
    sendByte({dev, 1'b0}, a);
    if (a) begin
      ackCnt++;
      if (regByte[7:6] != 2'b00) expQ.push_back(regByte[7:6]);
      sendByte(regByte, a); if (a) ackCnt++;
      for (int i = 0; i < n; i++) begin sendByte(wrBuf[i], a); if (a) ackCnt++; end
    end
    busStop();
    tick(4*Q);
  endtask

  task automatic readTxn(input logic [7:0] regByte, input int n);
    bit a;
    logic [7:0] b;
    ackCnt = 0;
    busStart();
    sendByte({DEV, 1'b0}, a); if (a) ackCnt++;
    sendByte(regByte, a); if (a) ackCnt++;
    busStart();
    sendByte({DEV, 1'b1}, a); if (a) ackCnt++;
    for (int i = 0; i < n; i++) begin recvByte(i == n - 1, b); rdBuf[i] = b; end
    busStop();
    tick(4*Q);
  endtask

  task automatic pulseFlag();
    intFlagSet = 1; tick(1); intFlagSet = 0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(5); rstN = 1; tick(5);
    // R7 reset state
    check("R7 cmd", cmdReg, 8'h00);
    check("R7 ctrl", ctrlReg, 8'h00);
    check("R7 thrHigh", thrHigh, 8'hFF);
    check("R7 thrLow", thrLow, 8'h00);
    check("R7 sdaOe", sdaOe, 1'b0);

    // R3 single write to command
    wrBuf[0] = 8'hA5; writeTxn(DEV, 8'h00, 1);
    check("R3 acks", ackCnt, 3);
    check("R3 cmd", cmdReg, 8'hA5);

    // R3 auto-increment across thresholds
    wrBuf[0] = 8'h12; wrBuf[1] = 8'h34; writeTxn(DEV, 8'h02, 2);
    check("R3 thrHigh", thrHigh, 8'h12);
    check("R3 thrLow", thrLow, 8'h34);

    // R1 neighbour address ignored
    wrBuf[0] = 8'h3C; writeTxn(7'h45, 8'h00, 1);
    check("R1 no ack", ackCnt, 0);
    check("R1 cmd unchanged", cmdReg, 8'hA5);

    // R4 R2 read via repeated start
    readTxn(8'h00, 1);
    check("R2 acks", ackCnt, 3);
    check("R4 read cmd", rdBuf[0], 8'hA5);
    check("R4 released", sdaOe, 1'b0);

    // R8 control register
    wrBuf[0] = 8'hFF; writeTxn(DEV, 8'h01, 1);
    check("R8 forced bits", ctrlReg, 8'h0F);
    pulseFlag();
    check("R8 flag set", ctrlReg, 8'h2F);
    wrBuf[0] = 8'h2F; writeTxn(DEV, 8'h01, 1);
    check("R8 write one keeps", ctrlReg, 8'h2F);
    wrBuf[0] = 8'h0C; writeTxn(DEV, 8'h01, 1);
    check("R8 write zero clears", ctrlReg, 8'h0C);

    // R6 clear command, address-only transaction
    pulseFlag();
    check("R6 flag preset", ctrlReg, 8'h2C);
    writeTxn(DEV, 8'h41, 0);
    check("R6 acks", ackCnt, 2);
    check("R6 flag cleared", ctrlReg, 8'h0C);

    // R5 sync command alone, then both commands
    writeTxn(DEV, 8'h80, 0);
    check("R5 acks", ackCnt, 2);
    writeTxn(DEV, 8'hC0, 0);
    check("R5 cmd untouched", cmdReg, 8'hA5);

    // R10 bits 5:3 ignored
    wrBuf[0] = 8'h77; writeTxn(DEV, 8'h3B, 1);
    check("R10 thrLow", thrLow, 8'h77);
    check("R10 thrHigh kept", thrHigh, 8'h12);

    // R9 read-only write acked, no effect
    wrBuf[0] = 8'h99; writeTxn(DEV, 8'h04, 1);
    check("R9 ack", ackCnt, 3);
    readTxn(8'h04, 1);
    check("R9 sensor low intact", rdBuf[0], 8'h34);

    // R11 coherent pair
    readTxn(8'h04, 2);
    check("R11 low", rdBuf[0], 8'h34);
    check("R11 high", rdBuf[1], 8'h12);
    sensorData = 16'hABCD;
    readTxn(8'h05, 1);
    check("R11 snapshot held", rdBuf[0], 8'h12);
    readTxn(8'h04, 2);
    check("R11 new low", rdBuf[0], 8'hCD);
    check("R11 new high", rdBuf[1], 8'hAB);

    // R11 timer pair and R3 pointer wrap 7 -> 0
    readTxn(8'h06, 3);
    check("R11 timer low", rdBuf[0], 8'h78);
    check("R11 timer high", rdBuf[1], 8'h56);
    check("R3 wrap", rdBuf[2], 8'hA5);

    check("R5 R6 all strobes seen", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule